// File: doc/BRIEF.md
# Prescaled auto-reload event timer

This block is an up-counting timer with a small register bus. It serves either as a periodic system tick or as a single deadline event. The input clock passes through a programmable divider. Each divider tick advances the counter by one. When the counter reaches the active reload limit, the block raises an update event and the counter returns to zero. Software can also force an update. The update sets a sticky flag. When enabled, the flag drives a level interrupt line.

In periodic mode the counter wraps and keeps running. In one-pulse mode the run bit clears itself after the first update. The divider value is buffered, and so is the reload limit when preloading is selected. A buffered value becomes active only on an update event, so software changes never cut a running period short. A parameter sets the counter to 16 or 32 bits. Software can find the width by writing all-ones to the reload register and reading the value back.

Top module: `evt_timer`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low.
- R2: Registers sit at byte offsets control 0x00, interrupt enable 0x0C, status 0x10, event generation 0x14, prescaler 0x28 and auto-reload 0x2C. Control bit 0 is run, bit 3 is one-pulse and bit 7 is reload preload. Read data appears on `bus_rdata` one clock after the read cycle.
- R3: While running, the counter advances once every (PSC+1) input clocks. An update occurs on the tick at which the counter is at or above the active reload value, and the counter returns to 0 on that tick. Updates therefore repeat every (ARR+1)*(PSC+1) clocks.
- R4: In one-pulse mode an update clears control bit 0, and no further updates occur. Control bit 3 stays set.
- R5: Writing 0 to the control register stops the counter, and no update follows.
- R6: A prescaler write is buffered. The new divide ratio applies only from the next update event.
- R7: With preload set, an auto-reload write becomes active only at the next update. With preload clear, it becomes active at once, and the running count continues toward the new value.
- R8: Writing 1 to bit 0 at offset 0x14 forces an update. This restarts the counter and the divider from 0, loads the buffered values and sets the flag. Reads of 0x14 return 0.
- R9: Status bit 0 is set by every update and cleared by writing 0 to it. Writing 1 to it has no effect.
- R10: `irq` is the registered AND of status bit 0 and interrupt-enable bit 0. It goes high one clock after both are set, and it stays high until the flag is cleared.
- R11: The auto-reload register holds CNT_W bits and the prescaler register holds PSC_W bits. In the 16-bit build, writing 0xFFFFFFFF to either register reads back 0x0000FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, one cycle after the read |
| irq | output | 1 | Level interrupt from the update flag |

## Verification
The bench measures the cycle distance between interrupt rises, so an off-by-one error in the divider or in the reload compare shows up as a period of 9 or 11 where 10 is expected. A preloaded reload value that leaks through early, or an unbuffered prescaler, changes the first period after the write. Lowering the limit below the live count without preload must still give an update within a few ticks; a design that compares only for equality would instead wrap through the full counter range and time out. One-pulse runs must leave the run bit clear and stay silent, and a write of 1 to the flag must not set it.

// File: rtl/evt_tmr_pkg.sv
package evt_tmr_pkg;

   localparam int REG_AW = 6;

   localparam logic [REG_AW-1:0] OFS_CTRL  = 6'h00;
   localparam logic [REG_AW-1:0] OFS_IEN   = 6'h0C;
   localparam logic [REG_AW-1:0] OFS_STAT  = 6'h10;
   localparam logic [REG_AW-1:0] OFS_EVGEN = 6'h14;
   localparam logic [REG_AW-1:0] OFS_PSC   = 6'h28;
   localparam logic [REG_AW-1:0] OFS_ARR   = 6'h2C;

   localparam int CTL_RUN_BIT  = 0;
   localparam int CTL_ONCE_BIT = 3;
   localparam int CTL_PRE_BIT  = 7;

   typedef struct packed {
      logic pre;
      logic once;
      logic run;
   } ctrl_t;

   typedef enum logic [2:0] {
      SEL_NONE, SEL_CTRL, SEL_IEN, SEL_STAT, SEL_EVGEN, SEL_PSC, SEL_ARR
   } reg_sel_e;

   function automatic reg_sel_e reg_decode(input logic [REG_AW-1:0] a);
      case (a)
         OFS_CTRL:  return SEL_CTRL;
         OFS_IEN:   return SEL_IEN;
         OFS_STAT:  return SEL_STAT;
         OFS_EVGEN: return SEL_EVGEN;
         OFS_PSC:   return SEL_PSC;
         OFS_ARR:   return SEL_ARR;
         default:   return SEL_NONE;
      endcase
   endfunction

endpackage

// File: rtl/evt_tmr_prescaler.sv
module evt_tmr_prescaler #(
   parameter int PSC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [PSC_W-1:0] psc_act,
   output logic             tick,
   output logic [PSC_W-1:0] psc_cnt
);

   assign tick = run && (psc_cnt == psc_act);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         psc_cnt <= '0;
      end else if (restart) begin
         psc_cnt <= '0;
      end else if (run) begin
         if (tick) psc_cnt <= '0;
         else      psc_cnt <= psc_cnt + 1'b1;
      end
   end

endmodule

// File: rtl/evt_tmr_counter.sv
module evt_tmr_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             restart,
   input  logic [CNT_W-1:0] arr_act,
   output logic [CNT_W-1:0] cnt,
   output logic             upd_nat
);

   logic at_limit;

   // At or above the limit: a limit lowered below the live count still ends the period.
   assign at_limit = (cnt >= arr_act);
   assign upd_nat  = tick && at_limit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (restart) begin
         cnt <= '0;
      end else if (tick) begin
         if (at_limit) cnt <= '0;
         else          cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/evt_tmr_regs.sv
module evt_tmr_regs
   import evt_tmr_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16,
   parameter int PSC_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [REG_AW-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              upd_nat,
   output ctrl_t             ctrl,
   output logic              ien,
   output logic              flag,
   output logic              force_upd,
   output logic              upd_any,
   output logic [PSC_W-1:0]  psc_act,
   output logic [CNT_W-1:0]  arr_act
);

   reg_sel_e          hit;
   logic              wr_ctrl, wr_ien, wr_stat, wr_evgen, wr_psc, wr_arr;
   logic [PSC_W-1:0]  psc_buf;
   logic [CNT_W-1:0]  arr_buf;
   logic [DATA_W-1:0] ctrl_word, arr_word, psc_word, rd_mux;
   logic              unused_wdata;

   assign unused_wdata = ^bus_wdata;

   always_comb hit = bus_sel ? reg_decode(bus_addr) : SEL_NONE;

   assign wr_ctrl  = bus_wr && (hit == SEL_CTRL);
   assign wr_ien   = bus_wr && (hit == SEL_IEN);
   assign wr_stat  = bus_wr && (hit == SEL_STAT);
   assign wr_evgen = bus_wr && (hit == SEL_EVGEN);
   assign wr_psc   = bus_wr && (hit == SEL_PSC);
   assign wr_arr   = bus_wr && (hit == SEL_ARR);

   assign force_upd = wr_evgen && bus_wdata[0];
   assign upd_any   = upd_nat || force_upd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else if (wr_ctrl) begin
         ctrl.run  <= bus_wdata[CTL_RUN_BIT];
         ctrl.once <= bus_wdata[CTL_ONCE_BIT];
         ctrl.pre  <= bus_wdata[CTL_PRE_BIT];
      end else if (upd_any && ctrl.once) begin
         ctrl.run  <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ien <= 1'b0;
      else if (wr_ien) ien <= bus_wdata[0];
   end

   // The hardware only sets the flag; software can only clear it.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          flag <= 1'b0;
      else if (upd_any)                    flag <= 1'b1;
      else if (wr_stat && !bus_wdata[0])   flag <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         psc_buf <= '0;
         psc_act <= '0;
      end else begin
         if (wr_psc)  psc_buf <= bus_wdata[PSC_W-1:0];
         if (upd_any) psc_act <= psc_buf;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arr_buf <= '0;
         arr_act <= '0;
      end else begin
         if (wr_arr) arr_buf <= bus_wdata[CNT_W-1:0];
         if (wr_arr && !ctrl.pre) arr_act <= bus_wdata[CNT_W-1:0];
         else if (upd_any)        arr_act <= arr_buf;
      end
   end

   generate
      if (CNT_W < DATA_W) begin : g_arr_pad
         assign arr_word = {{(DATA_W-CNT_W){1'b0}}, arr_buf};
      end else begin : g_arr_full
         assign arr_word = arr_buf;
      end
      if (PSC_W < DATA_W) begin : g_psc_pad
         assign psc_word = {{(DATA_W-PSC_W){1'b0}}, psc_buf};
      end else begin : g_psc_full
         assign psc_word = psc_buf;
      end
   endgenerate

   always_comb begin
      ctrl_word               = '0;
      ctrl_word[CTL_RUN_BIT]  = ctrl.run;
      ctrl_word[CTL_ONCE_BIT] = ctrl.once;
      ctrl_word[CTL_PRE_BIT]  = ctrl.pre;
   end

   always_comb begin
      rd_mux = '0;
      case (hit)
         SEL_CTRL: rd_mux = ctrl_word;
         SEL_IEN:  rd_mux[0] = ien;
         SEL_STAT: rd_mux[0] = flag;
         SEL_PSC:  rd_mux = psc_word;
         SEL_ARR:  rd_mux = arr_word;
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  bus_rdata <= '0;
      else if (bus_sel && !bus_wr) bus_rdata <= rd_mux;
   end

endmodule

// File: rtl/evt_timer.sv
module evt_timer
   import evt_tmr_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16,
   parameter int PSC_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [REG_AW-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);

   generate
      if (DATA_W != 32) begin : g_bad_data
         $error("evt_timer: DATA_W must be 32");
      end
      if (!(CNT_W == 16 || CNT_W == 32)) begin : g_bad_cnt
         $error("evt_timer: CNT_W must be 16 or 32");
      end
      if (PSC_W < 1 || PSC_W > DATA_W) begin : g_bad_psc
         $error("evt_timer: PSC_W out of range");
      end
   endgenerate

   ctrl_t            ctrl;
   logic             ien, flag, force_upd, upd_any, upd_nat, tick;
   logic [PSC_W-1:0] psc_act, psc_cnt;
   logic [CNT_W-1:0] arr_act, cnt;

   evt_tmr_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .upd_nat   (upd_nat),
      .ctrl      (ctrl),
      .ien       (ien),
      .flag      (flag),
      .force_upd (force_upd),
      .upd_any   (upd_any),
      .psc_act   (psc_act),
      .arr_act   (arr_act)
   );

   evt_tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (ctrl.run),
      .restart (force_upd),
      .psc_act (psc_act),
      .tick    (tick),
      .psc_cnt (psc_cnt)
   );

   evt_tmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .restart (force_upd),
      .arr_act (arr_act),
      .cnt     (cnt),
      .upd_nat (upd_nat)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= flag && ien;
   end

endmodule

// File: rtl/evt_tmr_checker.sv
module evt_tmr_checker
   import evt_tmr_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16,
   parameter int PSC_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [REG_AW-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              irq,
   input ctrl_t             ctrl,
   input logic              ien,
   input logic              flag,
   input logic              force_upd,
   input logic              upd_any,
   input logic [CNT_W-1:0]  cnt,
   input logic [PSC_W-1:0]  psc_cnt,
   input logic [PSC_W-1:0]  psc_act
);

   logic ctl_wr, stat_set_try, unused_chk;

   assign ctl_wr       = bus_sel && bus_wr && (bus_addr == OFS_CTRL);
   assign stat_set_try = bus_sel && bus_wr && (bus_addr == OFS_STAT) && bus_wdata[0];
   assign unused_chk   = ^bus_wdata;

   p_cnt_zero_after_upd_r3: assert property (@(posedge clk) disable iff (!rst_n)
      upd_any |=> (cnt == '0));

   p_div_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      psc_cnt <= psc_act);

   p_once_clears_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_any && ctrl.once && !ctl_wr) |=> !ctrl.run);

   p_stopped_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl.run && !force_upd) |=> $stable(cnt));

   p_upd_sets_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      upd_any |=> flag);

   p_no_sw_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag && stat_set_try && !upd_any) |=> !flag);

   p_irq_after_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(flag) && ien) |=> irq);

endmodule

bind evt_timer evt_tmr_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .irq       (irq),
   .ctrl      (ctrl),
   .ien       (ien),
   .flag      (flag),
   .force_upd (force_upd),
   .upd_any   (upd_any),
   .cnt       (cnt),
   .psc_cnt   (psc_cnt),
   .psc_act   (psc_act)
);

// File: tb/tb_evt_timer.sv
`timescale 1ns/1ps
module tb_evt_timer;
   import evt_tmr_pkg::*;

   localparam int DATA_W = 32;
   localparam int CNT_W  = 16;
   localparam int PSC_W  = 16;
   localparam logic [31:0] ARR_MASK = (CNT_W == 32) ? 32'hFFFF_FFFF : ((32'h1 << CNT_W) - 1);
   localparam logic [31:0] PSC_MASK = (PSC_W == 32) ? 32'hFFFF_FFFF : ((32'h1 << PSC_W) - 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_sel = 1'b0;
   logic              bus_wr = 1'b0;
   logic [REG_AW-1:0] bus_addr = '0;
   logic [DATA_W-1:0] bus_wdata = '0;
   logic [DATA_W-1:0] bus_rdata;
   logic              irq;

   int nchk = 0;
   int nfail = 0;
   int cyc = 0;
   bit done = 1'b0;

   logic [31:0] exp_q[$];
   string       tag_q[$];
   int          cyc_q[$];

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   evt_timer #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W)) dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
      end
   endtask

   // Monitor: compares read data one cycle after each queued read.
   always @(negedge clk) begin
      if (cyc_q.size() > 0 && cyc_q[0] == cyc - 1) begin
         chk(bus_rdata === exp_q[0], tag_q[0], bus_rdata, exp_q[0]);
         void'(cyc_q.pop_front());
         void'(exp_q.pop_front());
         void'(tag_q.pop_front());
      end
   end

   task automatic wr(input logic [REG_AW-1:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [REG_AW-1:0] a, input logic [31:0] exp, input string tag);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      cyc_q.push_back(cyc); exp_q.push_back(exp); tag_q.push_back(tag);
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic wait_rise(output int at);
      int n = 0;
      while (irq !== 1'b0 && n < 3000) begin @(negedge clk); n++; end
      while (irq !== 1'b1 && n < 3000) begin @(negedge clk); n++; end
      at = (n >= 3000) ? -100000 : cyc;
   endtask

   task automatic setup(input logic [31:0] psc, input logic [31:0] arr, input logic [31:0] c);
      wr(OFS_CTRL, 0);
      wr(OFS_ARR, arr);
      wr(OFS_PSC, psc);
      wr(OFS_EVGEN, 1);
      wr(OFS_STAT, 0);
      wr(OFS_CTRL, c);
   endtask

   initial begin
      int c0, r1, r2, r3, r4;
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(irq === 1'b0, "R1 irq after reset", irq, 0);
      rd(OFS_CTRL, 0, "R1 ctrl reset");
      rd(OFS_IEN,  0, "R1 ien reset");
      rd(OFS_STAT, 0, "R1 stat reset");
      rd(OFS_PSC,  0, "R1 psc reset");
      rd(OFS_ARR,  0, "R1 arr reset");

      // R2 control bits and offsets
      wr(OFS_CTRL, 32'h88);
      rd(OFS_CTRL, 32'h88, "R2 ctrl once+pre readback");
      wr(OFS_CTRL, 32'hFFFF_FF76);
      rd(OFS_CTRL, 32'h0, "R2 ctrl undefined bits read 0");

      // R11 width discovery
      wr(OFS_ARR, 32'hFFFF_FFFF);
      rd(OFS_ARR, ARR_MASK, "R11 arr width");
      wr(OFS_PSC, 32'hFFFF_FFFF);
      rd(OFS_PSC, PSC_MASK, "R11 psc width");

      // R8 forced update sets flag, event register reads 0
      wr(OFS_EVGEN, 1);
      rd(OFS_STAT, 1, "R8 forced update sets flag");
      rd(OFS_EVGEN, 0, "R8 event register reads 0");

      // R10 gating: flag set, enable off
      repeat (3) @(negedge clk);
      chk(irq === 1'b0, "R10 irq gated by enable", irq, 0);
      wr(OFS_IEN, 1);
      chk(irq === 1'b0, "R10 irq registered, not yet", irq, 0);
      @(negedge clk);
      chk(irq === 1'b1, "R10 irq one clock after enable", irq, 1);

      // R9 clear and set attempts
      wr(OFS_STAT, 32'hFFFF_FFFE);
      rd(OFS_STAT, 0, "R9 write 0 clears flag");
      chk(irq === 1'b0, "R10 irq drops after clear", irq, 0);
      wr(OFS_STAT, 1);
      rd(OFS_STAT, 0, "R9 write 1 ignored");
      chk(irq === 1'b0, "R9 irq stays low after write 1", irq, 0);

      // R3 period with psc=1 arr=4: (4+1)*(1+1)=10
      setup(1, 4, 32'h01);
      c0 = cyc;
      wait_rise(r1);
      chk(r1 - c0 == 11, "R3 first update cycle", r1 - c0, 11);
      wr(OFS_STAT, 0);
      wait_rise(r2);
      chk(r2 - r1 == 10, "R3 periodic spacing", r2 - r1, 10);

      // R6 buffered prescaler
      wr(OFS_STAT, 0);
      wr(OFS_PSC, 0);
      wait_rise(r3);
      chk(r3 - r2 == 10, "R6 old ratio until update", r3 - r2, 10);
      wr(OFS_STAT, 0);
      wait_rise(r4);
      chk(r4 - r3 == 5, "R6 new ratio after update", r4 - r3, 5);

      // R7 preload on
      wr(OFS_STAT, 0);
      wr(OFS_CTRL, 32'h81);
      wait_rise(r1);
      wr(OFS_STAT, 0);
      wr(OFS_ARR, 9);
      wait_rise(r2);
      chk(r2 - r1 == 5, "R7 preload keeps old limit", r2 - r1, 5);
      wr(OFS_STAT, 0);
      wait_rise(r3);
      chk(r3 - r2 == 10, "R7 preload applies at update", r3 - r2, 10);

      // R7 preload off: immediate
      wr(OFS_STAT, 0);
      wr(OFS_CTRL, 32'h01);
      wait_rise(r1);
      wr(OFS_STAT, 0);
      wr(OFS_ARR, 6);
      wait_rise(r2);
      chk(r2 - r1 == 7, "R7 immediate limit", r2 - r1, 7);

      // R3 limit lowered below live count
      wr(OFS_STAT, 0);
      wr(OFS_ARR, 1);
      wait_rise(r3);
      chk(r3 - r2 == 4, "R3 count above limit ends period", r3 - r2, 4);

      // R5 stop
      wr(OFS_CTRL, 0);
      wr(OFS_STAT, 0);
      repeat (40) @(negedge clk);
      chk(irq === 1'b0, "R5 stopped counter gives no update", irq, 0);

      // R4 one-pulse
      setup(0, 2, 32'h09);
      c0 = cyc;
      wait_rise(r1);
      chk(r1 - c0 == 4, "R4 one-pulse update cycle", r1 - c0, 4);
      rd(OFS_CTRL, 32'h08, "R4 run bit cleared");
      wr(OFS_STAT, 0);
      repeat (30) @(negedge clk);
      chk(irq === 1'b0, "R4 no second update", irq, 0);

      // R8 forced update restarts the count
      setup(0, 9, 32'h01);
      wait_rise(r1);
      wr(OFS_STAT, 0);
      repeat (3) @(negedge clk);
      wr(OFS_EVGEN, 1);
      c0 = cyc;
      wait_rise(r2);
      chk(r2 - c0 == 1, "R8 forced update raises irq", r2 - c0, 1);
      wr(OFS_STAT, 0);
      wait_rise(r3);
      chk(r3 - r2 == 10, "R8 count restarted from 0", r3 - r2, 10);
      wr(OFS_CTRL, 0);

      repeat (3) @(negedge clk);
      chk(cyc_q.size() == 0, "R2 all reads answered", cyc_q.size(), 0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

endmodule